// File: doc/BRIEF.md
# Hash-Checked Block Repair Search Engine

This controller repairs a 512-bit protected memory block that has just failed its integrity check. The MAC computation is not part of this block. The engine builds one candidate correction at a time and offers it to an external checker over a request/response handshake. It then waits a variable number of cycles for a pass or fail verdict. The first candidate that passes is returned as the repaired block. When the search space or a programmable attempt budget runs out, an uncorrectable verdict is raised so that execution can be aborted.

The block is made of two 256-bit read-blocks. Each read-block holds 64 chips that are 4 bits wide. For each read-block a stored 4-bit lane parity is compared against the data, and the difference (the syndrome) is given to the engine. Three search modes use this syndrome in different ways:
- A plain single-bit sweep that ignores the syndrome.
- A lane-guided single-bit search.
- A whole-chip search in which the syndrome is applied to one chip per read-block.

The engine remembers the chip that was repaired most recently in each read-block, so that a recurring hard fault is tried first.

Top module: `ivc_search_top`

## Requirements
- R1: Bit n of the block lies in read-block n/256, chip (n%256)/4, lane n%4. A chip flip XORs that read-block's syndrome into lanes 0..3 of the chosen chip.
- R2: Mode 2'b00 flips exactly one bit per candidate, in the order bit 0 up to bit 511, and ignores the syndromes.
- R3: Mode 2'b01 accepts a search only when exactly one syndrome is nonzero and that syndrome has a single set bit. It then tries chips 0 to 63 of that read-block. Any other syndrome pair gives an immediate uncorrectable result with zero attempts and without ever asserting busy.
- R4: Mode 2'b10 with both syndromes nonzero walks 4096 candidates: the read-block 0 chip is the outer loop and the read-block 1 chip is the inner loop, each counting up from 0. With one syndrome nonzero it walks that read-block's 64 chips. With both syndromes zero, or with mode 2'b11, the result is uncorrectable at once with zero attempts.
- R5: A pass in mode 2'b01 or 2'b10 records the chip used in every read-block whose syndrome is nonzero. A later search in those modes tries the recorded chips first, provided a chip is recorded for every active read-block, and then the full order from its start. Mode 2'b00 neither uses nor changes the record.
- R6: chk_req stays high with chk_blk stable until a one-cycle chk_rsp arrives, whatever the latency. chk_req is low for at least one cycle between candidates.
- R7: On a passing verdict, done_ok pulses for one cycle and blk_out holds the passing candidate until the next pass.
- R8: When the candidates run out, done_fail pulses for one cycle and blk_out keeps its earlier value.
- R9: attempts is cleared when a search is accepted, increments once per verdict, and holds after the result.
- R10: A nonzero lim ends the search with done_fail once lim verdicts have failed. A lim of 0 sets no budget.
- R11: busy rises in the cycle after an accepted start and falls in the same cycle as done_ok or done_fail. A start while busy is ignored.
- R12: After reset, busy, chk_req, done_ok, done_fail and attempts are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (sampled only while idle) |
| mode | input | 2 | 00 bit sweep, 01 lane-guided, 10 chip, 11 reserved |
| blk_in | input | 512 | Block that failed verification |
| syn0 | input | 4 | Lane syndrome of read-block 0 |
| syn1 | input | 4 | Lane syndrome of read-block 1 |
| lim | input | 13 | Attempt budget, 0 means unlimited |
| chk_req | output | 1 | Candidate offered to the checker |
| chk_blk | output | 512 | Candidate block |
| chk_rsp | input | 1 | One-cycle verdict strobe |
| chk_pass | input | 1 | Verdict, valid with chk_rsp |
| busy | output | 1 | Search in progress |
| done_ok | output | 1 | Repair found (pulse) |
| done_fail | output | 1 | Uncorrectable (pulse) |
| blk_out | output | 512 | Last repaired block |
| attempts | output | 13 | Verdicts counted in the last search |

## Verification
Some properties are checked on every cycle:
- The handshake holds the request and keeps the candidate stable.
- The two result pulses never occur together, and a result always comes with the fall of busy.
- No request is made while idle.
- The attempt count stays within the largest search.

Only the directed scenarios can show the rest: the exact candidate order in each mode, the effect of the recorded chips on the attempt count, the budget cut-off, and the rejection of malformed syndromes. The bench shows these by comparing attempt counts and repaired blocks against values derived from the error it injects.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  typedef enum logic [1:0] {
    MD_BIT  = 2'b00,
    MD_LANE = 2'b01,
    MD_CHIP = 2'b10,
    MD_RSVD = 2'b11
  } ivc_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WAIT = 2'b01,
    ST_ADV  = 2'b10
  } ivc_state_e;
endpackage

// File: rtl/ivc_cand.sv
module ivc_cand #(
  parameter int LANE_W = 4,
  parameter int CHIPS  = 64,
  localparam int RB_W  = LANE_W * CHIPS,
  localparam int BLK_W = 2 * RB_W,
  localparam int CI_W  = $clog2(CHIPS),
  localparam int BI_W  = $clog2(BLK_W)
) (
  input  logic [BLK_W-1:0]  blk,
  input  logic              bit_mode,
  input  logic [BI_W-1:0]   bit_idx,
  input  logic [CI_W-1:0]   c0,
  input  logic [CI_W-1:0]   c1,
  input  logic [LANE_W-1:0] s0,
  input  logic [LANE_W-1:0] s1,
  output logic [BLK_W-1:0]  cand
);
  logic [BLK_W-1:0] bit_flip;
  logic [BLK_W-1:0] chip_flip;

  // single-bit sweep mask
  for (genvar i = 0; i < BLK_W; i++) begin : g_bit
    assign bit_flip[i] = bit_mode && (bit_idx == BI_W'(i));
  end

  // per-chip syndrome mask, one chip per read-block
  for (genvar r = 0; r < 2; r++) begin : g_rb
    for (genvar c = 0; c < CHIPS; c++) begin : g_chip
      logic sel;
      if (r == 0) begin : g_r0
        assign sel = !bit_mode && (c0 == CI_W'(c));
        assign chip_flip[r*RB_W + c*LANE_W +: LANE_W] = sel ? s0 : '0;
      end else begin : g_r1
        assign sel = !bit_mode && (c1 == CI_W'(c));
        assign chip_flip[r*RB_W + c*LANE_W +: LANE_W] = sel ? s1 : '0;
      end
    end
  end

  assign cand = blk ^ bit_flip ^ chip_flip;
endmodule

// File: rtl/ivc_hint.sv
module ivc_hint #(
  parameter int CHIPS = 64,
  localparam int CI_W = $clog2(CHIPS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  logic            act0,
  input  logic            act1,
  input  logic [CI_W-1:0] c0,
  input  logic [CI_W-1:0] c1,
  output logic [CI_W-1:0] h0,
  output logic [CI_W-1:0] h1,
  output logic            hv0,
  output logic            hv1
);
  logic en0, en1;

  assign en0 = upd && act0;
  assign en1 = upd && act1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h0  <= '0;
      hv0 <= 1'b0;
    end else if (en0) begin
      h0  <= c0;
      hv0 <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1  <= '0;
      hv1 <= 1'b0;
    end else if (en1) begin
      h1  <= c1;
      hv1 <= 1'b1;
    end
  end
endmodule

// File: rtl/ivc_seq.sv
module ivc_seq
  import ivc_pkg::*;
#(
  parameter int LANE_W = 4,
  parameter int CHIPS  = 64,
  parameter int CNT_W  = 13,
  localparam int RB_W  = LANE_W * CHIPS,
  localparam int BLK_W = 2 * RB_W,
  localparam int CI_W  = $clog2(CHIPS),
  localparam int BI_W  = $clog2(BLK_W),
  localparam int IDX_W = (2*CI_W > BI_W) ? 2*CI_W : BI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode_i,
  input  logic [LANE_W-1:0] s0_i,
  input  logic [LANE_W-1:0] s1_i,
  input  logic [CNT_W-1:0]  lim_i,
  input  logic              rsp,
  input  logic              pass,
  input  logic [CI_W-1:0]   h0,
  input  logic [CI_W-1:0]   h1,
  input  logic              hv0,
  input  logic              hv1,
  output logic              accept,
  output logic              capture,
  output logic              chip_search,
  output logic              busy,
  output logic              req,
  output logic              bit_mode,
  output logic [BI_W-1:0]   bit_idx,
  output logic [CI_W-1:0]   c0,
  output logic [CI_W-1:0]   c1,
  output logic [LANE_W-1:0] s0,
  output logic [LANE_W-1:0] s1,
  output logic [CNT_W-1:0]  attempts,
  output logic              done_ok,
  output logic              done_fail
);
  localparam logic [IDX_W-1:0] LAST_BIT  = IDX_W'(BLK_W - 1);
  localparam logic [IDX_W-1:0] LAST_ONE  = IDX_W'(CHIPS - 1);
  localparam logic [IDX_W-1:0] LAST_PAIR = IDX_W'(CHIPS * CHIPS - 1);

  ivc_state_e        st_q, st_d;
  ivc_mode_e         md_q, md_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              hph_q, hph_d;
  logic [CNT_W-1:0]  att_q, att_d;
  logic [CNT_W-1:0]  lim_q, lim_d;
  logic [LANE_W-1:0] s0_q, s0_d, s1_q, s1_d;
  logic              ok_d, fl_d;
  logic              ok_q, fl_q;

  logic              nz0_i, nz1_i, valid_i, hint_i;
  logic              both_q;
  logic [IDX_W-1:0]  last;
  logic              lim_hit, exhausted;
  logic [CNT_W-1:0]  att_inc;

  // start qualification
  assign nz0_i = |s0_i;
  assign nz1_i = |s1_i;

  always_comb begin
    unique case (ivc_mode_e'(mode_i))
      MD_BIT:  valid_i = 1'b1;
      MD_LANE: valid_i = (nz0_i ^ nz1_i) &&
                         ($countones(nz0_i ? s0_i : s1_i) == 1);
      MD_CHIP: valid_i = nz0_i || nz1_i;
      default: valid_i = 1'b0;
    endcase
  end

  assign hint_i = (ivc_mode_e'(mode_i) != MD_BIT) && (nz0_i || nz1_i) &&
                  (!nz0_i || hv0) && (!nz1_i || hv1);

  // candidate index decode
  assign both_q   = (|s0_q) && (|s1_q);
  assign bit_mode = (md_q == MD_BIT);
  assign bit_idx  = idx_q[BI_W-1:0];

  always_comb begin
    if (hph_q) begin
      c0 = h0;
      c1 = h1;
    end else if (both_q) begin
      c0 = idx_q[2*CI_W-1:CI_W];
      c1 = idx_q[CI_W-1:0];
    end else begin
      c0 = idx_q[CI_W-1:0];
      c1 = idx_q[CI_W-1:0];
    end
  end

  always_comb begin
    if (bit_mode)    last = LAST_BIT;
    else if (both_q) last = LAST_PAIR;
    else             last = LAST_ONE;
  end

  assign att_inc   = att_q + CNT_W'(1);
  assign lim_hit   = (lim_q != '0) && (att_inc >= lim_q);
  assign exhausted = !hph_q && (idx_q == last);

  // next state
  always_comb begin
    st_d   = st_q;
    md_d   = md_q;
    idx_d  = idx_q;
    hph_d  = hph_q;
    att_d  = att_q;
    lim_d  = lim_q;
    s0_d   = s0_q;
    s1_d   = s1_q;
    ok_d   = 1'b0;
    fl_d   = 1'b0;
    accept = 1'b0;
    capture = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          accept = 1'b1;
          md_d   = ivc_mode_e'(mode_i);
          s0_d   = s0_i;
          s1_d   = s1_i;
          lim_d  = lim_i;
          att_d  = '0;
          idx_d  = '0;
          hph_d  = hint_i;
          if (valid_i) st_d = ST_WAIT;
          else         fl_d = 1'b1;
        end
      end
      ST_WAIT: begin
        if (rsp) begin
          att_d = att_inc;
          if (pass) begin
            capture = 1'b1;
            ok_d    = 1'b1;
            st_d    = ST_IDLE;
          end else if (lim_hit || exhausted) begin
            fl_d = 1'b1;
            st_d = ST_IDLE;
          end else begin
            if (hph_q) hph_d = 1'b0;
            else       idx_d = idx_q + IDX_W'(1);
            st_d = ST_ADV;
          end
        end
      end
      ST_ADV:  st_d = ST_WAIT;
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      md_q  <= MD_BIT;
      idx_q <= '0;
      hph_q <= 1'b0;
      att_q <= '0;
      lim_q <= '0;
      s0_q  <= '0;
      s1_q  <= '0;
      ok_q  <= 1'b0;
      fl_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      md_q  <= md_d;
      idx_q <= idx_d;
      hph_q <= hph_d;
      att_q <= att_d;
      lim_q <= lim_d;
      s0_q  <= s0_d;
      s1_q  <= s1_d;
      ok_q  <= ok_d;
      fl_q  <= fl_d;
    end
  end

  assign busy        = (st_q != ST_IDLE);
  assign req         = (st_q == ST_WAIT);
  assign chip_search = !bit_mode;
  assign s0          = s0_q;
  assign s1          = s1_q;
  assign attempts    = att_q;
  assign done_ok     = ok_q;
  assign done_fail   = fl_q;
endmodule

// File: rtl/ivc_search_top.sv
module ivc_search_top #(
  parameter int LANE_W = 4,
  parameter int CHIPS  = 64,
  parameter int CNT_W  = 13,
  localparam int RB_W  = LANE_W * CHIPS,
  localparam int BLK_W = 2 * RB_W,
  localparam int CI_W  = $clog2(CHIPS),
  localparam int BI_W  = $clog2(BLK_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [BLK_W-1:0]  blk_in,
  input  logic [LANE_W-1:0] syn0,
  input  logic [LANE_W-1:0] syn1,
  input  logic [CNT_W-1:0]  lim,
  output logic              chk_req,
  output logic [BLK_W-1:0]  chk_blk,
  input  logic              chk_rsp,
  input  logic              chk_pass,
  output logic              busy,
  output logic              done_ok,
  output logic              done_fail,
  output logic [BLK_W-1:0]  blk_out,
  output logic [CNT_W-1:0]  attempts
);
  logic [1:0]        rst_sync;
  logic              rst_li;
  logic              accept, capture, chip_search, bit_mode;
  logic [BI_W-1:0]   bit_idx;
  logic [CI_W-1:0]   c0, c1, h0, h1;
  logic              hv0, hv1;
  logic [LANE_W-1:0] s0, s1;
  logic [BLK_W-1:0]  blk_q, cand;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_li = rst_sync[1];

  ivc_seq #(.LANE_W(LANE_W), .CHIPS(CHIPS), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_li), .start(start), .mode_i(mode),
    .s0_i(syn0), .s1_i(syn1), .lim_i(lim), .rsp(chk_rsp), .pass(chk_pass),
    .h0(h0), .h1(h1), .hv0(hv0), .hv1(hv1),
    .accept(accept), .capture(capture), .chip_search(chip_search),
    .busy(busy), .req(chk_req), .bit_mode(bit_mode), .bit_idx(bit_idx),
    .c0(c0), .c1(c1), .s0(s0), .s1(s1), .attempts(attempts),
    .done_ok(done_ok), .done_fail(done_fail)
  );

  ivc_cand #(.LANE_W(LANE_W), .CHIPS(CHIPS)) u_cand (
    .blk(blk_q), .bit_mode(bit_mode), .bit_idx(bit_idx),
    .c0(c0), .c1(c1), .s0(s0), .s1(s1), .cand(cand)
  );

  ivc_hint #(.CHIPS(CHIPS)) u_hint (
    .clk(clk), .rst_n(rst_li), .upd(capture && chip_search),
    .act0(|s0), .act1(|s1), .c0(c0), .c1(c1),
    .h0(h0), .h1(h1), .hv0(hv0), .hv1(hv1)
  );

  always_ff @(posedge clk or negedge rst_li) begin
    if (!rst_li)     blk_q <= '0;
    else if (accept) blk_q <= blk_in;
  end

  always_ff @(posedge clk or negedge rst_li) begin
    if (!rst_li)      blk_out <= '0;
    else if (capture) blk_out <= cand;
  end

  assign chk_blk = cand;
endmodule

// File: rtl/ivc_search_chk.sv
module ivc_search_chk #(
  parameter int BLK_W = 512,
  parameter int CNT_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chk_req,
  input logic [BLK_W-1:0] chk_blk,
  input logic             chk_rsp,
  input logic             busy,
  input logic             done_ok,
  input logic             done_fail,
  input logic [CNT_W-1:0] attempts
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_req && !chk_rsp) |=> chk_req); // R6
  AST_CAND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_req && !chk_rsp) |=> $stable(chk_blk)); // R6
  AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_req && chk_rsp) |=> !chk_req); // R6
  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ok && done_fail)); // R7
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !chk_req); // R11
  AST_BUSY_ENDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done_ok || done_fail)); // R11
  AST_ATT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    attempts <= CNT_W'(4097)); // R9
endmodule

bind ivc_search_top ivc_search_chk #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chk_req(chk_req), .chk_blk(chk_blk),
  .chk_rsp(chk_rsp), .busy(busy), .done_ok(done_ok), .done_fail(done_fail),
  .attempts(attempts)
);

// File: tb/test_ivc_search_top.sv
module test_ivc_search_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [511:0] blk_in = '0;
  logic [3:0]   syn0 = '0, syn1 = '0;
  logic [12:0]  lim = '0;
  logic         chk_req;
  logic [511:0] chk_blk;
  logic         chk_rsp = 1'b0, chk_pass = 1'b0;
  logic         busy, done_ok, done_fail;
  logic [511:0] blk_out;
  logic [12:0]  attempts;

  int unsigned  n_chk = 0, n_bad = 0;
  logic [511:0] golden = '0;
  logic         busy_seen;
  int unsigned  cyc = 0;

  always #2.5 clk = ~clk;

  ivc_search_top i_ivc_search_top (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .blk_in(blk_in),
    .syn0(syn0), .syn1(syn1), .lim(lim), .chk_req(chk_req), .chk_blk(chk_blk),
    .chk_rsp(chk_rsp), .chk_pass(chk_pass), .busy(busy), .done_ok(done_ok),
    .done_fail(done_fail), .blk_out(blk_out), .attempts(attempts)
  );

  task automatic check(input string rq, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        finish_run();
      end
    end
  end

  // variable-latency MAC checker model
  initial begin
    int cnt = 0;
    int lat = 1;
    forever begin
      @(negedge clk);
      if (chk_rsp) begin
        chk_rsp = 1'b0;
      end else if (chk_req) begin
        cnt++;
        if (cnt >= lat) begin
          chk_rsp  = 1'b1;
          chk_pass = (chk_blk == golden);
          cnt = 0;
          lat = (lat % 5) + 1;
        end
      end
    end
  end

  function automatic logic [511:0] base(input int k);
    logic [511:0] b;
    for (int i = 0; i < 16; i++) b[i*32 +: 32] = 32'h9E37_79B9 * (i + 1) + k;
    return b;
  endfunction

  // lane syndrome of a read-block (R1 layout)
  function automatic logic [3:0] lsyn(input logic [511:0] err, input int rb);
    logic [3:0] s = '0;
    for (int c = 0; c < 64; c++) s ^= err[rb*256 + c*4 +: 4];
    return s;
  endfunction

  function automatic logic [511:0] chip_err(input int rb, input int c, input logic [3:0] p);
    logic [511:0] e = '0;
    e[rb*256 + c*4 +: 4] = p;
    return e;
  endfunction

  task automatic run(input logic [1:0] md, input logic [511:0] err, input logic [12:0] lm,
                     input bit poke_busy, output logic ok, output logic fl);
    @(negedge clk);
    mode = md; blk_in = golden ^ err; syn0 = lsyn(err, 0); syn1 = lsyn(err, 1);
    lim = lm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy_seen = busy;
    if (poke_busy) begin
      @(negedge clk);
      @(negedge clk);
      busy_seen = busy_seen | busy;
      mode = 2'b00; blk_in = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int t = 0; t < 40000 && !(done_ok || done_fail); t++) @(negedge clk);
    ok = done_ok;
    fl = done_fail;
    @(negedge clk);
    // pulses are one cycle wide
    check("R7 pulse width", {done_ok, done_fail}, 2'b00);
  endtask

  task automatic t_reset();
    check("R12 reset busy", busy, 1'b0);
    check("R12 reset req", chk_req, 1'b0);
    check("R12 reset done", {done_ok, done_fail}, 2'b00);
    check("R12 reset attempts", attempts, 13'd0);
  endtask

  task automatic t_bit_sweep();
    logic ok, fl;
    logic [511:0] e = '0;
    golden = base(1);
    e[300] = 1'b1;
    run(2'b00, e, 13'd0, 1'b0, ok, fl);
    check("R2 bit sweep pass", ok, 1'b1);
    check("R2 bit sweep attempts", attempts, 13'd301);
    check("R7 bit sweep block", blk_out, golden);
    check("R11 busy seen", busy_seen, 1'b1);
  endtask

  task automatic t_lane_first();
    logic ok, fl;
    golden = base(2);
    run(2'b01, chip_err(0, 10, 4'b0100), 13'd0, 1'b0, ok, fl);
    check("R3 lane pass", ok, 1'b1);
    check("R3 lane attempts", attempts, 13'd11);
    check("R1 R7 lane block", blk_out, golden);
  endtask

  task automatic t_lane_hint_hit();
    logic ok, fl;
    golden = base(3);
    run(2'b01, chip_err(0, 10, 4'b0010), 13'd0, 1'b0, ok, fl);
    check("R5 hint hit attempts", attempts, 13'd1);
    check("R5 hint hit block", blk_out, golden);
  endtask

  task automatic t_lane_hint_miss();
    logic ok, fl;
    golden = base(4);
    run(2'b01, chip_err(0, 3, 4'b0001), 13'd0, 1'b0, ok, fl);
    check("R5 hint miss attempts", attempts, 13'd5);
    check("R5 hint miss pass", ok, 1'b1);
  endtask

  task automatic t_chip_pair();
    logic ok, fl;
    golden = base(5);
    run(2'b10, chip_err(0, 2, 4'b1011) ^ chip_err(1, 5, 4'b0110), 13'd0, 1'b0, ok, fl);
    check("R4 pair pass", ok, 1'b1);
    check("R4 pair attempts", attempts, 13'd134);
    check("R4 pair block", blk_out, golden);
  endtask

  task automatic t_limit();
    logic ok, fl;
    logic [511:0] prev;
    prev = golden;
    golden = base(6);
    run(2'b10, chip_err(0, 50, 4'b0001) ^ chip_err(1, 60, 4'b1000), 13'd20, 1'b0, ok, fl);
    check("R10 limit fail", {ok, fl}, 2'b01);
    check("R10 limit attempts", attempts, 13'd20);
    check("R8 block kept", blk_out, prev);
  endtask

  task automatic t_lane_exhaust();
    logic ok, fl;
    logic [511:0] e;
    golden = base(7);
    e = chip_err(1, 7, 4'b0100) ^ chip_err(0, 1, 4'b0001) ^ chip_err(0, 9, 4'b0001);
    run(2'b01, e, 13'd0, 1'b0, ok, fl);
    check("R8 exhaust fail", {ok, fl}, 2'b01);
    check("R5 R8 exhaust attempts", attempts, 13'd65);
  endtask

  task automatic t_chip_single();
    logic ok, fl;
    golden = base(8);
    run(2'b10, chip_err(1, 40, 4'b1111), 13'd0, 1'b1, ok, fl);
    check("R4 single pass", ok, 1'b1);
    check("R4 R11 single attempts", attempts, 13'd42);
    check("R11 start while busy ignored", blk_out, golden);
  endtask

  task automatic t_rejects();
    logic ok, fl;
    golden = base(9);
    run(2'b01, chip_err(0, 4, 4'b0001) ^ chip_err(1, 4, 4'b0001), 13'd0, 1'b0, ok, fl);
    check("R3 two syndromes rejected", {ok, fl, busy_seen}, 3'b010);
    check("R3 rejected attempts", attempts, 13'd0);
    run(2'b01, chip_err(0, 4, 4'b0011), 13'd0, 1'b0, ok, fl);
    check("R3 multi-bit syndrome rejected", {ok, fl, busy_seen}, 3'b010);
    run(2'b11, chip_err(0, 4, 4'b0001), 13'd0, 1'b0, ok, fl);
    check("R4 reserved mode rejected", {ok, fl, busy_seen}, 3'b010);
    run(2'b10, '0, 13'd0, 1'b0, ok, fl);
    check("R4 zero syndromes rejected", {ok, fl, busy_seen}, 3'b010);
    check("R9 R8 block kept after reject", blk_out, base(8));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bit_sweep();
    t_lane_first();
    t_lane_hint_hit();
    t_lane_hint_miss();
    t_chip_pair();
    t_limit();
    t_lane_exhaust();
    t_chip_single();
    t_rejects();
    finish_run();
  end
endmodule